// File: doc/BRIEF.md
# GPIO Port with Per-Pin Function Mux

This block is a parameterised port of general-purpose pins. Each pin belongs either to software-driven GPIO or to one of several on-chip peripherals. A per-pin function-enable bit makes that choice. A per-pin select field in a wide mux register names which peripheral receives the pad.

In GPIO use, the output latch and the direction come from registers. Both can be changed one bit at a time through set and clear aliases, so no read-modify-write is needed. A separate input-enable bit gates the input path for each pin.

Pad inputs go through a two-stage synchronizer before any other logic sees them. The synchronized value, gated by input-enable, is also driven out as a vector for an interrupt controller.

The register port is a single-cycle write strobe with a combinational read. The address is decoded as a word index.

Top module: `gpio_fmux_port`

## Requirements
- R1: After reset, every register reads 0, and `pad_oe`, `pad_out` and `irq_vec` are 0. Every pin is therefore a GPIO input with its input path gated off.
- R2: For a pin whose function-enable bit is 0:
  - `pad_out` follows the data latch.
  - `pad_oe` follows the direction bit.
- R3: For a pin whose function-enable bit is 1, `pad_out` and `pad_oe` come from the selected peripheral. Peripheral k's buses occupy bits [k*NPINS +: NPINS] of `per_out` and `per_oe`.
- R4: The mux register (word 1, 32 bits) holds the select code of pin p at bits [2p+1:2p]. Writing it replaces all fields, and reading it returns them unchanged. A software read-modify-write of one field leaves the other pins' routing as it was.
- R5: Writing word 3 sets the data-latch bits whose written value is 1. Writing word 4 clears them. Bits written as 0 leave the latch unchanged. Word 2 writes the latch directly, and reading word 3 or word 4 returns the latch.
- R6: Writing word 5 makes the pins whose bits are 1 outputs. Writing word 6 makes them inputs. Reading either word returns the direction vector, where 1 means output.
- R7: Making a pin an output clears its input-enable bit, and making it an input sets it. Word 7 reads and writes input-enable directly without touching direction.
- R8: Reading word 2 returns:
  - the latch for output pins;
  - the synchronized pad for input pins with input-enable set;
  - 0 for input pins with input-enable clear.
- R9: A pad change becomes visible in the read of word 2 after exactly two rising clock edges.
- R10: `irq_vec` equals the synchronized pad vector ANDed with input-enable.
- R11: Writes to word indices 8 to 15 change nothing, and reads of them return 0. Word 0 is the function-enable register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | AW | Register word index |
| bus_wdata | input | NPINS*SELW | Write data |
| bus_rdata | output | NPINS*SELW | Combinational read data |
| per_out | input | NFUNC*NPINS | Peripheral output values, one NPINS slice per function |
| per_oe | input | NFUNC*NPINS | Peripheral output enables, one NPINS slice per function |
| pad_in | input | NPINS | Asynchronous pad input |
| pad_out | output | NPINS | Pad output value |
| pad_oe | output | NPINS | Pad output enable |
| irq_vec | output | NPINS | Synchronized, input-enable-gated pin levels |

## Verification
The bench builds the port with its defaults: sixteen pins, four functions, a 32-bit mux register and a 4-bit address. With these values every select code on a pin can be reached, including pin 15's top field at bits 31:30. The 4-bit address also gives room for the unused word indices 8 to 15. The chosen peripheral patterns make function 0 and function 3 show up on distinct pad bits. This distinguishes a routing error from a mux field that is misplaced.

// File: rtl/gpio_fmux_port.sv
module gpio_fmux_port #(
  parameter int NPINS = 16,
  parameter int NFUNC = 4,
  parameter int AW    = 4,
  localparam int SELW = $clog2(NFUNC),
  localparam int DW   = NPINS * SELW
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr,
  input  logic [AW-1:0]          bus_addr,
  input  logic [DW-1:0]          bus_wdata,
  output logic [DW-1:0]          bus_rdata,
  input  logic [NFUNC*NPINS-1:0] per_out,
  input  logic [NFUNC*NPINS-1:0] per_oe,
  input  logic [NPINS-1:0]       pad_in,
  output logic [NPINS-1:0]       pad_out,
  output logic [NPINS-1:0]       pad_oe,
  output logic [NPINS-1:0]       irq_vec
);
  localparam logic [AW-1:0] A_FEN  = AW'(0);
  localparam logic [AW-1:0] A_MUX  = AW'(1);
  localparam logic [AW-1:0] A_DAT  = AW'(2);
  localparam logic [AW-1:0] A_DSET = AW'(3);
  localparam logic [AW-1:0] A_DCLR = AW'(4);
  localparam logic [AW-1:0] A_OSET = AW'(5);
  localparam logic [AW-1:0] A_OCLR = AW'(6);
  localparam logic [AW-1:0] A_IEN  = AW'(7);

  logic [NPINS-1:0] dout, dir, inen, fer, sy1, sy2;
  logic [DW-1:0]    mux;
  logic [NPINS-1:0] wn, rd_pins;

  assign wn = bus_wdata[NPINS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
      dir  <= '0;
      inen <= '0;
      fer  <= '0;
      mux  <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_FEN:  fer  <= wn;
        A_MUX:  mux  <= bus_wdata;
        A_DAT:  dout <= wn;
        A_DSET: dout <= dout | wn;
        A_DCLR: dout <= dout & ~wn;
        A_OSET: begin dir <= dir | wn;  inen <= inen & ~wn; end
        A_OCLR: begin dir <= dir & ~wn; inen <= inen | wn;  end
        A_IEN:  inen <= wn;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
    end else begin
      sy1 <= pad_in;
      sy2 <= sy1;
    end
  end

  assign rd_pins = (dout & dir) | (sy2 & inen & ~dir);
  assign irq_vec = sy2 & inen;

  always_comb begin
    case (bus_addr)
      A_FEN:          bus_rdata = DW'(fer);
      A_MUX:          bus_rdata = mux;
      A_DAT:          bus_rdata = DW'(rd_pins);
      A_DSET, A_DCLR: bus_rdata = DW'(dout);
      A_OSET, A_OCLR: bus_rdata = DW'(dir);
      A_IEN:          bus_rdata = DW'(inen);
      default:        bus_rdata = '0;
    endcase
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic [SELW-1:0] sel;
    assign sel        = mux[i*SELW +: SELW];
    assign pad_out[i] = fer[i] ? per_out[int'(sel)*NPINS + i] : dout[i];
    assign pad_oe[i]  = fer[i] ? per_oe[int'(sel)*NPINS + i]  : dir[i];
  end
endmodule

// File: rtl/gpio_fmux_port_chk.sv
module gpio_fmux_port_chk #(
  parameter int NPINS = 16,
  parameter int DW    = 32,
  parameter int AW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [AW-1:0]    bus_addr,
  input logic [DW-1:0]    bus_wdata,
  input logic [NPINS-1:0] pad_in,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] irq_vec,
  input logic [NPINS-1:0] dout,
  input logic [NPINS-1:0] dir,
  input logic [NPINS-1:0] inen,
  input logic [NPINS-1:0] fer
);
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;

  logic [NPINS-1:0] wn;
  assign wn = bus_wdata[NPINS-1:0];

  p_gpio_pad_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (((pad_out ^ dout) | (pad_oe ^ dir)) & ~fer) == '0);

  p_data_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(3)) |=> ((dout & $past(wn)) == $past(wn)));

  p_data_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(4)) |=> ((dout & $past(wn)) == '0));

  p_out_gates_inen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(5)) |=>
      (((inen & $past(wn)) == '0) && ((dir & $past(wn)) == $past(wn))));

  p_in_opens_inen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(6)) |=>
      (((inen & $past(wn)) == $past(wn)) && ((dir & $past(wn)) == '0)));

  p_sync_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> (irq_vec == ($past(pad_in, 2) & inen)));
endmodule

bind gpio_fmux_port gpio_fmux_port_chk #(.NPINS(NPINS), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
  .irq_vec(irq_vec), .dout(dout), .dir(dir), .inen(inen), .fer(fer)
);

// File: tb/tb_gpio_fmux_port.sv
`timescale 1ns/1ps
module tb_gpio_fmux_port;
  localparam int NPINS = 16, NFUNC = 4, AW = 4, DW = 32;
  localparam int NV = 11;
  // {write addr, write data, read addr, expected read}
  localparam logic [AW+DW+AW+DW-1:0] VEC [NV] = '{
    {4'd1,  32'hE4E4E4E4, 4'd1,  32'hE4E4E4E4},  // R4
    {4'd2,  32'h000000FF, 4'd3,  32'h000000FF},  // R5
    {4'd3,  32'h00000F00, 4'd4,  32'h00000FFF},  // R5
    {4'd4,  32'h0000000F, 4'd3,  32'h00000FF0},  // R5
    {4'd5,  32'h000000F0, 4'd6,  32'h000000F0},  // R6
    {4'd7,  32'h0000FFFF, 4'd7,  32'h0000FFFF},  // R7
    {4'd5,  32'h00000F00, 4'd7,  32'h0000F0FF},  // R7
    {4'd6,  32'h00000030, 4'd5,  32'h00000FC0},  // R6
    {4'd7,  32'h00000000, 4'd6,  32'h00000FC0},  // R7
    {4'd0,  32'h00008001, 4'd0,  32'h00008001},  // R11
    {4'd10, 32'hFFFFFFFF, 4'd10, 32'h00000000}   // R11
  };
  localparam string VTAG [NV] = '{"R4","R5","R5","R5","R6","R7","R7","R6","R7","R11","R11"};

  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  logic [NFUNC*NPINS-1:0] per_out = '0, per_oe = '0;
  logic [NPINS-1:0] pad_in = '0, pad_out, pad_oe, irq_vec;
  int errors = 0, checks = 0;
  logic [DW-1:0] tmp;

  always #2.5 clk = ~clk;

  gpio_fmux_port #(.NPINS(NPINS), .NFUNC(NFUNC), .AW(AW)) dut (.*);

  task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog: got hung expected done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(AW'(a), tmp);
      check("R1 reg", tmp, '0);
    end
    check("R1 pad_oe", DW'(pad_oe), '0);
    check("R1 pad_out", DW'(pad_out), '0);
    check("R1 irq_vec", DW'(irq_vec), '0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][AW+DW+AW+DW-1 -: AW], VEC[i][DW+AW+DW-1 -: DW]);
      rd(VEC[i][AW+DW-1 -: AW], tmp);
      check(VTAG[i], tmp, VEC[i][DW-1:0]);
    end

    // state: dout=0FF0 dir=0FC0 inen=0 fer=8001 mux=E4E4E4E4
    per_out = 64'h8000_0000_0000_0000;
    per_oe  = 64'hFFFF_0000_0000_0001;
    #1;
    check("R2/R3 pad_out", DW'(pad_out), 32'h8FF0);
    check("R2/R3 pad_oe",  DW'(pad_oe),  32'h8FC1);

    // R4 read-modify-write of pin 0 field to function 3
    rd(AW'(1), tmp);
    wr(AW'(1), (tmp & ~32'h3) | 32'h3);
    rd(AW'(1), tmp);
    check("R4 rmw", tmp, 32'hE4E4E4E7);
    per_out = 64'h8001_0000_0000_0000;
    #1;
    check("R3 pin0 func3 out", DW'(pad_out), 32'h8FF1);
    check("R3 pin0 func3 oe", DW'(pad_oe), 32'h8FC1);

    // R8/R9/R10 input path
    wr(AW'(7), 32'hF00F);
    pad_in = 16'hAAAA;
    @(posedge clk); @(negedge clk);
    rd(AW'(2), tmp);
    check("R9 one edge", tmp, 32'h0FC0);
    check("R10 one edge", DW'(irq_vec), 32'h0);
    @(posedge clk); @(negedge clk);
    rd(AW'(2), tmp);
    check("R8/R9 two edges", tmp, 32'hAFCA);
    check("R10 irq", DW'(irq_vec), 32'hA00A);
    wr(AW'(5), 32'h000F);
    rd(AW'(2), tmp);
    check("R8 latch on new outputs", tmp, 32'hAFC0);
    check("R10 gated after output", DW'(irq_vec), 32'hA000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule